// File: doc/BRIEF.md
# Clock-Independent Periodic Tick Generator

This block produces a steady system tick of roughly 125 Hz. It does this even though the clock that drives it can run at any of sixteen rates between 4 and 16 MHz. The clock first passes through a fixed divide-by-16 prescaler. A first down-counter then divides the prescaler's wrap pulses by a first constant. A second down-counter divides the first counter's terminal pulses by a second constant, and it has no prescaler of its own.

A 4-bit speed code names the current clock rate. It selects a pair of constants from a built-in table, so 16 × first × second stays close to the clock frequency divided by 125. Only the second stage produces output. Each of its terminal counts gives a one-clock tick pulse and sets a level interrupt request. The request stays set until it is acknowledged.

When the speed code changes, the prescaler is cleared and both counters reload the new pair. A fresh tick period then starts.

Top module: `cascade_tick_gen`

## Requirements
- R1: While reset (active low, asynchronous) is held, `tick` and `irq` are 0.
- R2: The number of clock cycles between successive `tick` pulses equals 16 × A × B. Here (A, B) is the table pair for the current `speed_sel`.
- R3: The table pairs (A, B) for speed codes 0 to 15, in code order, are: (16,125) (18,127) (23,107) (21,127) (15,194) (25,128) (28,127) (32,125) (17,251) (36,127) (46,107) (42,127) (23,253) (50,128) (56,127) (64,125). Codes 0, 5, 7, 13 and 15 give an exact 125 Hz tick at 4, 6.4, 8, 12.8 and 16 MHz respectively.
- R4: After reset is released with `speed_sel` = 0, the first `tick` appears exactly 16 × A × B clock edges later.
- R5: A change of `speed_sel` is taken at the next clock edge, which restarts the period. The next `tick` follows exactly 16 × A × B further edges, using the new pair. No tick occurs in between.
- R6: `irq` becomes 1 together with each `tick` and holds until `irq_ack` is sampled high, which clears it on that edge. If a tick and an acknowledge meet on the same edge, `irq` stays 1.
- R7: `tick` is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 4 | Clock-rate code selecting the constant pair |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| tick | output | 1 | One-clock pulse per tick period |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted prescaler, a wrong counter value or a wrong table entry does not show up at once. It shows up only when the next tick arrives early or late. That happens up to one full period later, several tens of thousands of cycles.

The bench therefore measures whole periods for three speed codes. It also checks the restart by changing the code in the middle of a period, so a missing reload shows as a period that is too short. An interrupt flag with the wrong set or clear logic shows within a cycle of a tick or an acknowledge, and the bench compares it against its model on every clock.

// File: rtl/cascade_tick_gen.sv
module cascade_tick_gen #(
  parameter int PRESCALE = 16,
  parameter int CW       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] speed_sel,
  input  logic       irq_ack,
  output logic       tick,
  output logic       irq
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  function automatic logic [2*CW-1:0] const_pair(input logic [3:0] s);
    int a, b;
    case (s)
      4'd0:  begin a = 16; b = 125; end
      4'd1:  begin a = 18; b = 127; end
      4'd2:  begin a = 23; b = 107; end
      4'd3:  begin a = 21; b = 127; end
      4'd4:  begin a = 15; b = 194; end
      4'd5:  begin a = 25; b = 128; end
      4'd6:  begin a = 28; b = 127; end
      4'd7:  begin a = 32; b = 125; end
      4'd8:  begin a = 17; b = 251; end
      4'd9:  begin a = 36; b = 127; end
      4'd10: begin a = 46; b = 107; end
      4'd11: begin a = 42; b = 127; end
      4'd12: begin a = 23; b = 253; end
      4'd13: begin a = 50; b = 128; end
      4'd14: begin a = 56; b = 127; end
      default: begin a = 64; b = 125; end
    endcase
    return {CW'(a), CW'(b)};
  endfunction

  logic [CW-1:0] c1_new, c2_new;
  logic [3:0]    sel_q;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt1, cnt2;

  assign {c1_new, c2_new} = const_pair(speed_sel);

  wire sel_chg  = speed_sel != sel_q;
  wire pre_wrap = pre == PRE_LAST;
  wire zc1      = pre_wrap && (cnt1 == CW'(1));
  wire term2    = zc1 && (cnt2 == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= 4'd0;
      pre          <= '0;
      {cnt1, cnt2} <= const_pair(4'd0);
      tick         <= 1'b0;
      irq          <= 1'b0;
    end else if (sel_chg) begin
      sel_q <= speed_sel;
      pre   <= '0;
      cnt1  <= c1_new;
      cnt2  <= c2_new;
      tick  <= 1'b0;
      irq   <= irq && !irq_ack;
    end else begin
      pre <= pre_wrap ? '0 : pre + PW'(1);
      if (pre_wrap) cnt1 <= (cnt1 == CW'(1)) ? c1_new : cnt1 - CW'(1);
      if (zc1)      cnt2 <= (cnt2 == CW'(1)) ? c2_new : cnt2 - CW'(1);
      tick <= term2;
      if (term2)        irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  p_tick_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_restart_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> !tick);
  p_irq_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> irq);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !term2) |=> !irq);
  p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt1 != '0) && (cnt2 != '0));
endmodule

// File: tb/tb_cascade_tick_gen.sv
module tb_cascade_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] speed_sel = 4'd0;
  logic irq_ack = 1'b0;
  logic tick, irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cascade_tick_gen dut (.clk(clk), .rst_n(rst_n), .speed_sel(speed_sel),
                        .irq_ack(irq_ack), .tick(tick), .irq(irq));

  function automatic int period_of(input int s);
    int a[16] = '{16, 18, 23, 21, 15, 25, 28, 32, 17, 36, 46, 42, 23, 50, 56, 64};
    int b[16] = '{125, 127, 107, 127, 194, 128, 127, 125, 251, 127, 107, 127, 253, 128, 127, 125};
    return 16 * a[s] * b[s];
  endfunction

  int  phase = 0;
  int  lsel = 0;
  bit  etick = 0;
  bit  eirq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; lsel = 0; etick = 0; eirq = 0;
    end else if (int'(speed_sel) != lsel) begin
      lsel = int'(speed_sel); phase = 0; etick = 0;
      eirq = eirq && !irq_ack;
    end else begin
      phase++;
      if (phase == period_of(lsel)) begin
        phase = 0; etick = 1; eirq = 1;
      end else begin
        etick = 0;
        if (irq_ack) eirq = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (tick !== etick) begin
      failures++;
      $display("FAIL R2 model tick act=%0b exp=%0b t=%0t", tick, etick, $time);
    end
    checks++;
    if (irq !== eirq) begin
      failures++;
      $display("FAIL R6 model irq act=%0b exp=%0b t=%0t", irq, eirq, $time);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 200000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 tick in reset", int'(tick), 0);
    check("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    begin
      int n;
      wait_tick(n);
      check("R4 first period code0", n, 32000);
      check("R3 code0 exact 4MHz product", period_of(0), 4000000 / 125);
      check("R6 irq set with tick", int'(irq), 1);
      @(negedge clk);
      check("R7 tick one wide", int'(tick), 0);
      wait_tick(n);
      check("R2 second period code0", n + 1, 32000);
      @(negedge clk);
      check("R6 irq held without ack", int'(irq), 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check("R6 ack clears irq", int'(irq), 0);
      repeat (1000) @(negedge clk);
      speed_sel = 4'd2;
      wait_tick(n);
      check("R5 restart period code2", n, period_of(2) + 1);
      check("R2 code2 period value", period_of(2), 39376);
      check("R6 irq after code2 tick", int'(irq), 1);
      speed_sel = 4'd4;
      repeat (period_of(4)) @(negedge clk);
      check("R5 no tick before end code4", int'(tick), 0);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check("R2 tick at 16*15*194 code4", int'(tick), 1);
      check("R6 tick wins over ack", int'(irq), 1);
      @(negedge clk);
      check("R7 tick one wide code4", int'(tick), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired R2 act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule